// File: doc/BRIEF.md
# Power Management Capability Register Set

This block holds the power management capability structure of a PCI Express function's configuration space. It answers the configuration read/write port at two dword addresses. The first dword holds the capability identifier, the link to the next capability and a read-only word of capability flags. The second dword holds the power-state control and status word and a read-only data byte. The device drives a power management event strobe into the block and supplies a byte of power figures for each data-select value. The block drives the current power state and the no-soft-reset flag back to the device.

Software moves the function between D0, D1, D2 and D3hot by writing the two-bit state field. Requests for a state that the function does not support are dropped. A pending event is latched in a sticky status bit, which software clears by writing one to it. A four-bit select field chooses which power figure shows in the data byte. When a configuration write takes the function from D3hot back to D0 and the no-soft-reset flag is clear, the block performs an internal reset of the software-owned fields.

Top module: `pm_cap_regs`

## Requirements
- R1: After reset, the power state is D0 (encoding 00 in control/status bits 1:0), PME enable (bit 8), data select (bits 12:9) and PME status (bit 15) are zero, and pwr_state reads 0.
- R2: The first dword at CAP_DW reads capability ID 01h in bits 7:0, NEXT_PTR in bits 15:8, and a capabilities word in bits 31:16 with version in 18:16, PME clock (always 0) in 19, device-specific init in 21, aux current in 24:22, D1 support in 25, D2 support in 26 and the PME state mask in 31:27. Writes to it change nothing.
- R3: A write to dword CAP_DW+1 with byte enable 0 set loads bits 1:0 into the power state when the state is D0 (00) or D3hot (11). The new state shows at pwr_state and in the register in the following cycle.
- R4: A write that requests D1 (01) while D1_SUP is 0, or D2 (10) while D2_SUP is 0, is ignored and the power state keeps its value.
- R5: PME enable is read/write at bit 8 and data select at bits 12:9, both under byte enable 1. A write with byte enable 1 clear leaves them unchanged.
- R6: A one-cycle pulse on pme_event sets PME status (bit 15) whatever PME enable holds, and the bit stays set.
- R7: Writing 1 to bit 15 under byte enable 1 clears PME status, while writing 0 leaves it unchanged. An event in the same cycle as a clear leaves the bit set.
- R8: For a select value k below NUM_DATA, bits 31:24 read byte k of pwr_data and bits 14:13 read DATA_SCALE. For k of NUM_DATA or above, both fields read zero.
- R9: Bit 3 of control/status and no_soft_rst both reflect NO_SOFT_RESET. An accepted write from D3hot to D0 with that flag clear resets PME enable and data select to zero, overriding the same write's byte 1, and leaves PME status intact.
- R10: Reads of any other dword return zero, and writes to any other dword change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | ADDR_W | Configuration dword address |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| pme_event | input | 1 | Power management event pulse from the device |
| pwr_data | input | max(NUM_DATA,1)*8 | Power figures, byte k for select value k |
| pwr_state | output | 2 | Current power state (00 D0, 01 D1, 10 D2, 11 D3hot) |
| no_soft_rst | output | 1 | No-soft-reset flag |

## Verification
The state field is driven with every request value from both D0 and D3hot. This separates accepted targets from dropped ones and shows whether the D3hot-to-D0 path fires the internal reset. The status bit is driven with a write of 0, a write of 1, an event alone, and an event coinciding with a clear, which distinguishes sticky, cleared and event-priority behaviour. The select field is swept over entries inside and past NUM_DATA so that a wrong byte index and a missing zero fill show as different values. Writes with partial byte enables and writes to foreign dwords show whether either leaks into state.

// File: rtl/pm_cap_pkg.sv
package pm_cap_pkg;
   typedef enum logic [1:0] {
      PM_D0  = 2'b00,
      PM_D1  = 2'b01,
      PM_D2  = 2'b10,
      PM_D3H = 2'b11
   } pm_state_t;

   localparam logic [7:0] PM_CAP_ID      = 8'h01;
   localparam int         PM_SEL_W       = 4;
   localparam int         PM_MAX_ENTRIES = 1 << PM_SEL_W;
   localparam int         PM_STS_BIT     = 15;
endpackage

// File: rtl/pm_cap_state.sv
module pm_cap_state
   import pm_cap_pkg::*;
#(
   parameter bit D1_SUP        = 1'b1,
   parameter bit D2_SUP        = 1'b0,
   parameter bit NO_SOFT_RESET = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_stb,
   input  logic [1:0] req,
   output pm_state_t  state,
   output logic       soft_rst
);
   pm_state_t req_st;
   logic      legal;

   assign req_st = pm_state_t'(req);

   always_comb begin
      unique case (req_st)
         PM_D1:   legal = D1_SUP;
         PM_D2:   legal = D2_SUP;
         default: legal = 1'b1;
      endcase
   end

   generate
      if (NO_SOFT_RESET) begin : g_nsr
         assign soft_rst = 1'b0;
      end else begin : g_sr
         assign soft_rst = wr_stb && legal && (state == PM_D3H) && (req_st == PM_D0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               state <= PM_D0;
      else if (wr_stb && legal) state <= req_st;
   end
endmodule

// File: rtl/pm_cap_pme.sv
module pm_cap_pme
   import pm_cap_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                soft_rst,
   input  logic                wr_stb,
   input  logic [7:0]          wr_byte,
   input  logic                event_in,
   output logic                pme_en,
   output logic [PM_SEL_W-1:0] data_sel,
   output logic                pme_sts
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pme_en   <= 1'b0;
         data_sel <= '0;
      end else if (soft_rst) begin
         pme_en   <= 1'b0;
         data_sel <= '0;
      end else if (wr_stb) begin
         pme_en   <= wr_byte[0];
         data_sel <= wr_byte[PM_SEL_W:1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         pme_sts <= 1'b0;
      else if (event_in)                  pme_sts <= 1'b1;
      else if (wr_stb && wr_byte[PM_STS_BIT-8]) pme_sts <= 1'b0;
   end
endmodule

// File: rtl/pm_cap_data.sv
module pm_cap_data
   import pm_cap_pkg::*;
#(
   parameter int         NUM_DATA   = 8,
   parameter logic [1:0] DATA_SCALE = 2'd1,
   localparam int        PD_W       = ((NUM_DATA > 0) ? NUM_DATA : 1) * 8
) (
   input  logic [PM_SEL_W-1:0] sel,
   input  logic [PD_W-1:0]     pwr_data,
   output logic [7:0]          data_byte,
   output logic [1:0]          scale
);
   generate
      if (NUM_DATA == 0) begin : g_none
         logic unused_pd;
         assign unused_pd = ^{pwr_data, sel};
         assign data_byte = 8'h00;
         assign scale     = 2'b00;
      end else begin : g_table
         logic hit;
         assign hit = (int'(sel) < NUM_DATA);
         always_comb begin
            data_byte = 8'h00;
            for (int k = 0; k < NUM_DATA; k++)
               if (int'(sel) == k) data_byte = pwr_data[k*8 +: 8];
         end
         assign scale = hit ? DATA_SCALE : 2'b00;
      end
   endgenerate
endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
   import pm_cap_pkg::*;
#(
   parameter int         ADDR_W        = 10,
   parameter int         CAP_DW        = 16,
   parameter logic [7:0] NEXT_PTR      = 8'h50,
   parameter logic [2:0] VERSION       = 3'd3,
   parameter bit         DSI           = 1'b0,
   parameter logic [2:0] AUX_CUR       = 3'd0,
   parameter bit         D1_SUP        = 1'b1,
   parameter bit         D2_SUP        = 1'b0,
   parameter logic [4:0] PME_MASK      = 5'b11001,
   parameter bit         NO_SOFT_RESET = 1'b0,
   parameter int         NUM_DATA      = 8,
   parameter logic [1:0] DATA_SCALE    = 2'd1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [ADDR_W-1:0]                     cfg_addr,
   input  logic                                  cfg_wr,
   input  logic [3:0]                            cfg_be,
   input  logic [31:0]                           cfg_wdata,
   output logic [31:0]                           cfg_rdata,
   input  logic                                  pme_event,
   input  logic [((NUM_DATA > 0) ? NUM_DATA : 1)*8-1:0] pwr_data,
   output logic [1:0]                            pwr_state,
   output logic                                  no_soft_rst
);
   localparam logic [ADDR_W-1:0] DW_HDR = ADDR_W'(CAP_DW);
   localparam logic [ADDR_W-1:0] DW_CSR = ADDR_W'(CAP_DW + 1);
   localparam logic [15:0] CAPS = {PME_MASK, D2_SUP, D1_SUP, AUX_CUR, DSI, 1'b0, 1'b0, VERSION};

   initial begin
      if (NUM_DATA < 0 || NUM_DATA > PM_MAX_ENTRIES)
         $error("pm_cap_regs: NUM_DATA out of range");
      if (CAP_DW + 1 >= (1 << ADDR_W))
         $error("pm_cap_regs: CAP_DW does not fit ADDR_W");
      if (NEXT_PTR[1:0] != 2'b00)
         $error("pm_cap_regs: NEXT_PTR must be dword aligned");
   end

   pm_state_t           st;
   logic                soft_rst;
   logic                pme_en;
   logic [PM_SEL_W-1:0] data_sel;
   logic                pme_sts;
   logic [7:0]          data_byte;
   logic [1:0]          scale;
   logic                csr_wr;
   logic [15:0]         csr;
   logic                unused_wd;

   assign csr_wr    = cfg_wr && (cfg_addr == DW_CSR);
   assign unused_wd = ^{cfg_wdata[31:16], cfg_wdata[7:2], cfg_be[3:2]};

   pm_cap_state #(
      .D1_SUP(D1_SUP), .D2_SUP(D2_SUP), .NO_SOFT_RESET(NO_SOFT_RESET)
   ) u_state (
      .clk(clk), .rst_n(rst_n),
      .wr_stb(csr_wr && cfg_be[0]), .req(cfg_wdata[1:0]),
      .state(st), .soft_rst(soft_rst)
   );

   pm_cap_pme u_pme (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_stb(csr_wr && cfg_be[1]), .wr_byte(cfg_wdata[15:8]),
      .event_in(pme_event),
      .pme_en(pme_en), .data_sel(data_sel), .pme_sts(pme_sts)
   );

   pm_cap_data #(.NUM_DATA(NUM_DATA), .DATA_SCALE(DATA_SCALE)) u_data (
      .sel(data_sel), .pwr_data(pwr_data),
      .data_byte(data_byte), .scale(scale)
   );

   assign csr = {pme_sts, scale, data_sel, pme_en, 4'b0000, NO_SOFT_RESET, 1'b0, st};

   always_comb begin
      if (cfg_addr == DW_HDR)      cfg_rdata = {CAPS, NEXT_PTR, PM_CAP_ID};
      else if (cfg_addr == DW_CSR) cfg_rdata = {data_byte, 8'h00, csr};
      else                         cfg_rdata = 32'h0;
   end

   assign pwr_state   = st;
   assign no_soft_rst = NO_SOFT_RESET;
endmodule

// File: rtl/pm_cap_regs_chk.sv
module pm_cap_regs_chk #(
   parameter int ADDR_W        = 10,
   parameter int CAP_DW        = 16,
   parameter bit D1_SUP        = 1'b1,
   parameter bit D2_SUP        = 1'b0,
   parameter bit NO_SOFT_RESET = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic              cfg_wr,
   input logic [3:0]        cfg_be,
   input logic [31:0]       cfg_wdata,
   input logic [31:0]       cfg_rdata,
   input logic              pme_event,
   input logic [1:0]        pwr_state,
   input logic              pme_en,
   input logic [3:0]        data_sel,
   input logic              pme_sts
);
   logic csr_wr;
   assign csr_wr = cfg_wr && (cfg_addr == ADDR_W'(CAP_DW + 1));

   assert_cap_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == ADDR_W'(CAP_DW)) |-> (cfg_rdata[7:0] == 8'h01 && cfg_rdata[19] == 1'b0));

   assert_state_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(csr_wr && cfg_be[0]) |=> $stable(pwr_state));

   assert_unsup_d1_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!D1_SUP && csr_wr && cfg_be[0] && cfg_wdata[1:0] == 2'b01) |=> $stable(pwr_state));

   assert_unsup_d2_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!D2_SUP && csr_wr && cfg_be[0] && cfg_wdata[1:0] == 2'b10) |=> $stable(pwr_state));

   assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pme_event |=> pme_sts);

   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pme_sts && !(csr_wr && cfg_be[1] && cfg_wdata[15])) |=> pme_sts);

   assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!NO_SOFT_RESET && csr_wr && cfg_be[0] && pwr_state == 2'b11 && cfg_wdata[1:0] == 2'b00)
      |=> (!pme_en && data_sel == 4'h0));

   assert_foreign_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr != ADDR_W'(CAP_DW) && cfg_addr != ADDR_W'(CAP_DW + 1)) |-> (cfg_rdata == 32'h0));
endmodule

bind pm_cap_regs pm_cap_regs_chk #(
   .ADDR_W(ADDR_W), .CAP_DW(CAP_DW), .D1_SUP(D1_SUP),
   .D2_SUP(D2_SUP), .NO_SOFT_RESET(NO_SOFT_RESET)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
   .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
   .pme_event(pme_event), .pwr_state(pwr_state), .pme_en(pme_en),
   .data_sel(data_sel), .pme_sts(pme_sts)
);

// File: tb/pm_cap_regs_bench.sv
module pm_cap_regs_bench;
   localparam int ADDR_W = 10;
   localparam int HDR    = 16;
   localparam int CSR    = 17;
   localparam int ND     = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] cfg_addr = '0;
   logic              cfg_wr = 1'b0;
   logic [3:0]        cfg_be = '0;
   logic [31:0]       cfg_wdata = '0;
   logic [31:0]       cfg_rdata;
   logic              pme_event = 1'b0;
   logic [ND*8-1:0]   pwr_data;
   logic [1:0]        pwr_state;
   logic              no_soft_rst;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   initial for (int k = 0; k < ND; k++) pwr_data[k*8 +: 8] = 8'(8'hA0 + k * 5);

   pm_cap_regs u_pm_cap_regs (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
      .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .pme_event(pme_event), .pwr_data(pwr_data),
      .pwr_state(pwr_state), .no_soft_rst(no_soft_rst)
   );

   function automatic logic [31:0] exp_csr(input logic [1:0] st, input logic en,
                                           input logic [3:0] sel, input logic sts);
      logic [7:0] d;
      logic [1:0] sc;
      d  = (int'(sel) < ND) ? 8'(8'hA0 + int'(sel) * 5) : 8'h00;
      sc = (int'(sel) < ND) ? 2'b01 : 2'b00;
      return {d, 8'h00, sts, sc, sel, en, 4'b0000, 1'b0, 1'b0, st};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d, input logic ev);
      @(negedge clk);
      cfg_addr = ADDR_W'(a); cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1; pme_event = ev;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = '0; pme_event = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = ADDR_W'(a);
      #1 d = cfg_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(CSR, v);
      check("R1 reset csr", v, exp_csr(2'b00, 1'b0, 4'h0, 1'b0));
      check("R1 reset state", {30'b0, pwr_state}, 32'h0);
   endtask

   task automatic t_header;
      logic [31:0] v;
      rd(HDR, v);
      check("R2 header", v, 32'hCA035001);
      wr(HDR, 4'hF, 32'hFFFFFFFF, 1'b0);
      rd(HDR, v);
      check("R2 header after write", v, 32'hCA035001);
      check("R9 no_soft_rst pin", {31'b0, no_soft_rst}, 32'h0);
   endtask

   task automatic t_state;
      logic [31:0] v;
      wr(CSR, 4'h1, 32'h3, 1'b0);
      check("R3 pin D3hot", {30'b0, pwr_state}, 32'h3);
      wr(CSR, 4'h1, 32'h1, 1'b0);
      rd(CSR, v);
      check("R3 D1 accepted", v, exp_csr(2'b01, 1'b0, 4'h0, 1'b0));
      wr(CSR, 4'h1, 32'h0, 1'b0);
      check("R3 back to D0", {30'b0, pwr_state}, 32'h0);
   endtask

   task automatic t_unsup;
      wr(CSR, 4'h1, 32'h2, 1'b0);
      check("R4 D2 ignored from D0", {30'b0, pwr_state}, 32'h0);
      wr(CSR, 4'h1, 32'h3, 1'b0);
      wr(CSR, 4'h1, 32'h2, 1'b0);
      check("R4 D2 ignored from D3hot", {30'b0, pwr_state}, 32'h3);
      wr(CSR, 4'h2, 32'h0, 1'b0);
      check("R4 be0 clear keeps state", {30'b0, pwr_state}, 32'h3);
      wr(CSR, 4'h1, 32'h1, 1'b0);
      wr(CSR, 4'h1, 32'h0, 1'b0);
   endtask

   task automatic t_pme_en;
      logic [31:0] v;
      wr(CSR, 4'h2, 32'h0100, 1'b0);
      rd(CSR, v);
      check("R5 enable set", v, exp_csr(2'b00, 1'b1, 4'h0, 1'b0));
      wr(CSR, 4'h1, 32'h0000, 1'b0);
      rd(CSR, v);
      check("R5 be1 clear keeps enable", v, exp_csr(2'b00, 1'b1, 4'h0, 1'b0));
      wr(CSR, 4'h2, 32'h0000, 1'b0);
   endtask

   task automatic t_pme_sts;
      logic [31:0] v;
      wr(CSR, 4'h0, 32'h0, 1'b1);
      rd(CSR, v);
      check("R6 event with enable clear", v, exp_csr(2'b00, 1'b0, 4'h0, 1'b1));
      wr(CSR, 4'h2, 32'h0000, 1'b0);
      rd(CSR, v);
      check("R7 write 0 keeps status", v, exp_csr(2'b00, 1'b0, 4'h0, 1'b1));
      wr(CSR, 4'h2, 32'h8000, 1'b0);
      rd(CSR, v);
      check("R7 write 1 clears", v, exp_csr(2'b00, 1'b0, 4'h0, 1'b0));
      wr(CSR, 4'h2, 32'h8000, 1'b1);
      rd(CSR, v);
      check("R7 event beats clear", v, exp_csr(2'b00, 1'b0, 4'h0, 1'b1));
      wr(CSR, 4'h2, 32'h8000, 1'b0);
   endtask

   task automatic t_data;
      logic [31:0] v;
      for (int s = 0; s < 16; s += 3) begin
         wr(CSR, 4'h2, 32'(s << 9), 1'b0);
         rd(CSR, v);
         check($sformatf("R8 select %0d", s), v, exp_csr(2'b00, 1'b0, 4'(s), 1'b0));
      end
      wr(CSR, 4'h2, 32'h0000, 1'b0);
   endtask

   task automatic t_soft;
      logic [31:0] v;
      wr(CSR, 4'h0, 32'h0, 1'b1);
      wr(CSR, 4'h3, 32'h0703, 1'b0);
      rd(CSR, v);
      check("R9 setup in D3hot", v, exp_csr(2'b11, 1'b1, 4'h3, 1'b1));
      wr(CSR, 4'h3, 32'h0500, 1'b0);
      rd(CSR, v);
      check("R9 soft reset to D0", v, exp_csr(2'b00, 1'b0, 4'h0, 1'b1));
      wr(CSR, 4'h3, 32'h0701, 1'b0);
      wr(CSR, 4'h1, 32'h0000, 1'b0);
      rd(CSR, v);
      check("R9 D1 to D0 keeps fields", v, exp_csr(2'b00, 1'b1, 4'h3, 1'b1));
      wr(CSR, 4'h2, 32'h8000, 1'b0);
   endtask

   task automatic t_foreign;
      logic [31:0] v;
      rd(CSR + 1, v);
      check("R10 foreign read", v, 32'h0);
      wr(HDR - 1, 4'hF, 32'hFFFF_FFFF, 1'b0);
      wr(CSR + 1, 4'hF, 32'hFFFF_FFFF, 1'b0);
      rd(CSR, v);
      check("R10 foreign write no effect", v, exp_csr(2'b00, 1'b0, 4'h0, 1'b0));
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_header;
      t_state;
      t_unsup;
      t_pme_en;
      t_pme_sts;
      t_data;
      t_soft;
      t_foreign;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule